// File: doc/BRIEF.md
# Machine Cycle Beat Generator

This block paces a synchronous controller through each machine cycle. A cycle is cut into beats, one clock each: T1, T2, T3 and then T4. Every beat carries one micro-operation or one group of micro-operations that run in parallel. The generator drives one one-hot line per beat, plus a pulse that marks the last beat of the cycle.

The block uses combined control. A cycle that stays inside the processor runs on the fixed four-beat schedule. A cycle that reaches main memory or an I/O port waits on that device's ready signal. When the device is not ready at the end of T3, the generator inserts wait beats (TW) until ready rises. Any number of wait beats may be inserted. The cycle then closes with T4.

The controller tells the block, through `ext_access`, which kind of cycle it is starting. Choosing the next machine cycle and decoding instructions are not part of this block.

Top module: `cycle_beat_gen`

## Requirements
- R1: A high `rst` at a rising clock edge places the generator in T1 on the next cycle. This holds from any beat, including TW.
- R2: `beat_o` is one-hot on every clock. The bit positions are: bit 0 = T1, bit 1 = T2, bit 2 = T3, bit 3 = T4, bit 4 = TW.
- R3: An internal cycle (`ext_access` low) runs T1, T2, T3, T4 and then returns to T1, one beat per clock. `ready` has no effect on it.
- R4: The kind of access is sampled on the clock edge that ends T1. Later changes to `ext_access` do not alter the cycle in progress.
- R5: In an external cycle, a high `ready` on the edge that ends T3 moves the generator straight to T4, with no wait beat.
- R6: In an external cycle, a low `ready` on the edge that ends T3 enters TW. The generator stays in TW for as many clocks as `ready` stays low. It moves to T4 on the first edge that sees `ready` high.
- R7: `wait_o` is high exactly while the generator is in TW.
- R8: `cycle_end_o` is high for exactly one clock, during T4, and the next beat is T1.
- R9: `ready` has no effect in T1, T2 or T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_access | input | 1 | High when the cycle starting now goes to memory or I/O |
| ready | input | 1 | Device ready for the external access |
| beat_o | output | 5 | One-hot beat: T1, T2, T3, T4, TW from bit 0 upward |
| wait_o | output | 1 | High during a wait beat |
| cycle_end_o | output | 1 | High during T4, the last beat of the cycle |

## Verification
If the beat register holds a wrong value, it shows at `beat_o` in the same clock, because the outputs are decoded from that register with no further stage. A wrong transition therefore appears one clock after the edge that caused it. The latched access kind is held inside the block. An error there stays hidden until the edge that ends T3, where the block either enters TW or skips it when it should not. The bench finds it there, two clocks after the edge that ends T1, by driving `ext_access` against the latched kind mid-cycle.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

  localparam int BEAT_OUT_W = 5;
  localparam int BEAT_ST_W  = 3;

  typedef enum logic [BEAT_ST_W-1:0] {
    BT_T1 = 3'd0,
    BT_T2 = 3'd1,
    BT_T3 = 3'd2,
    BT_TW = 3'd3,
    BT_T4 = 3'd4
  } beat_e;

  // Transition rule for one clock.
  // ext_kind is the kind of access latched at the end of T1.
  function automatic beat_e next_beat(beat_e cur, logic ext_kind, logic rdy);
    beat_e nxt;
    case (cur)
      BT_T1:   nxt = BT_T2;
      BT_T2:   nxt = BT_T3;
      BT_T3:   nxt = (ext_kind && !rdy) ? BT_TW : BT_T4;
      BT_TW:   nxt = rdy ? BT_T4 : BT_TW;
      default: nxt = BT_T1;
    endcase
    return nxt;
  endfunction

  // One-hot line layout: T1, T2, T3, T4, TW from bit 0 upward.
  function automatic logic [BEAT_OUT_W-1:0] beat_onehot(beat_e b);
    logic [BEAT_OUT_W-1:0] v;
    v = '0;
    case (b)
      BT_T1:   v[0] = 1'b1;
      BT_T2:   v[1] = 1'b1;
      BT_T3:   v[2] = 1'b1;
      BT_T4:   v[3] = 1'b1;
      default: v[4] = 1'b1;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/mcb_beat_seq.sv
module mcb_beat_seq
  import mcb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ext_access,
  input  logic  ready,
  output beat_e cur_beat,
  output logic  kind_ext
);

  beat_e beat_q;
  logic  kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= BT_T1;
      kind_q <= 1'b0;
    end else begin
      beat_q <= next_beat(beat_q, kind_q, ready);
      // R4: the access kind is captured only on the edge that leaves T1.
      if (beat_q == BT_T1) kind_q <= ext_access;
    end
  end

  assign cur_beat = beat_q;
  assign kind_ext = kind_q;

endmodule

// File: rtl/mcb_beat_dec.sv
module mcb_beat_dec
  import mcb_pkg::*;
(
  input  beat_e                  cur_beat,
  output logic [BEAT_OUT_W-1:0]  beat_o,
  output logic                   wait_o,
  output logic                   cycle_end_o
);

  always_comb begin
    beat_o      = beat_onehot(cur_beat);
    wait_o      = (cur_beat == BT_TW);
    cycle_end_o = (cur_beat == BT_T4);
  end

endmodule

// File: rtl/cycle_beat_gen.sv
module cycle_beat_gen
  import mcb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ext_access,
  input  logic                  ready,
  output logic [BEAT_OUT_W-1:0] beat_o,
  output logic                  wait_o,
  output logic                  cycle_end_o
);

  beat_e cur_beat_w;
  logic  kind_ext_w;

  mcb_beat_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .ext_access (ext_access),
    .ready      (ready),
    .cur_beat   (cur_beat_w),
    .kind_ext   (kind_ext_w)
  );

  mcb_beat_dec u_dec (
    .cur_beat    (cur_beat_w),
    .beat_o      (beat_o),
    .wait_o      (wait_o),
    .cycle_end_o (cycle_end_o)
  );

endmodule

// File: rtl/cycle_beat_gen_chk.sv
module cycle_beat_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       ready,
  input logic [4:0] beat_o,
  input logic       wait_o,
  input logic       cycle_end_o,
  input logic       kind_ext
);

  // R1
  reset_to_t1_chk: assert property (@(posedge clk) rst |=> beat_o == 5'b00001);

  // R2
  one_beat_chk: assert property (@(posedge clk) disable iff (rst) $countones(beat_o) == 1);

  // R3
  t1_to_t2_chk: assert property (@(posedge clk) disable iff (rst) beat_o[0] |=> beat_o[1]);

  // R3
  t2_to_t3_chk: assert property (@(posedge clk) disable iff (rst) beat_o[1] |=> beat_o[2]);

  // R3
  internal_no_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_o[2] && !kind_ext) |=> beat_o[3]);

  // R5
  ready_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_o[2] && ready) |=> beat_o[3]);

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_o[4] && !ready) |=> beat_o[4]);

  // R6
  wait_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_o[4] && ready) |=> beat_o[3]);

  // R7
  wait_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wait_o |-> (beat_o[4] && !cycle_end_o));

  // R8
  end_then_t1_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_end_o |=> (beat_o[0] && !cycle_end_o));

endmodule

bind cycle_beat_gen cycle_beat_gen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .ready       (ready),
  .beat_o      (beat_o),
  .wait_o      (wait_o),
  .cycle_end_o (cycle_end_o),
  .kind_ext    (kind_ext_w)
);

// File: tb/tb_cycle_beat_gen.sv
`timescale 1ns/1ps
module tb_cycle_beat_gen;

  localparam logic [4:0] B1 = 5'b00001;
  localparam logic [4:0] B2 = 5'b00010;
  localparam logic [4:0] B3 = 5'b00100;
  localparam logic [4:0] B4 = 5'b01000;
  localparam logic [4:0] BW = 5'b10000;
  localparam int NVEC = 25;

  // Each vector is {ext_access, ready, expected beat in the current clock}.
  localparam logic [6:0] VEC [NVEC] = '{
    {1'b0, 1'b0, B1},  // R3 internal cycle starts
    {1'b0, 1'b0, B2},
    {1'b0, 1'b0, B3},  // R3 ready low, internal: no wait
    {1'b0, 1'b1, B4},  // R8
    {1'b1, 1'b0, B1},  // external kind latched here
    {1'b0, 1'b0, B2},  // R4 ext dropped, ignored
    {1'b0, 1'b1, B3},  // R5 ready at end of T3
    {1'b0, 1'b0, B4},
    {1'b1, 1'b1, B1},  // R9 ready in T1 ignored
    {1'b0, 1'b1, B2},  // R9 ready in T2 ignored
    {1'b0, 1'b0, B3},  // R6 not ready -> TW
    {1'b0, 1'b0, BW},  // R7
    {1'b1, 1'b0, BW},
    {1'b0, 1'b1, BW},  // R6 ready -> T4
    {1'b0, 1'b0, B4},
    {1'b1, 1'b0, B1},
    {1'b0, 1'b1, B2},  // R9
    {1'b0, 1'b0, B3},
    {1'b0, 1'b1, BW},  // R6 single wait beat
    {1'b0, 1'b0, B4},
    {1'b0, 1'b1, B1},  // internal kind
    {1'b1, 1'b0, B2},  // R4 ext raised late, ignored
    {1'b0, 1'b0, B3},
    {1'b1, 1'b0, B4},  // R9 ready low in T4 ignored
    {1'b1, 1'b0, B1}   // external kind for directed part
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       ext_access;
  logic       ready;
  logic [4:0] beat_o;
  logic       wait_o;
  logic       cycle_end_o;

  int applied = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  cycle_beat_gen dut (
    .clk         (clk),
    .rst         (rst),
    .ext_access  (ext_access),
    .ready       (ready),
    .beat_o      (beat_o),
    .wait_o      (wait_o),
    .cycle_end_o (cycle_end_o)
  );

  // Wait and end flags are derived from the expected beat (R7, R8).
  // The one-hot property is checked alongside (R2).
  task automatic chk(input string tag, input logic [4:0] exp);
    logic [6:0] act, want;
    act  = {beat_o, wait_o, cycle_end_o};
    want = {exp, exp[4], exp[3]};
    applied++;
    if (act !== want || $countones(beat_o) != 1) begin
      fails++;
      $display("FAIL %s actual beat=%b wait=%b end=%b expected beat=%b wait=%b end=%b",
               tag, beat_o, wait_o, cycle_end_o, exp, exp[4], exp[3]);
    end
  endtask

  initial begin
    rst = 1'b1; ext_access = 1'b0; ready = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1 reset state", B1);
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      ext_access = VEC[i][6];
      ready      = VEC[i][5];
      chk($sformatf("R2/R3/R4/R5/R6/R7/R8/R9 vector %0d", i), VEC[i][4:0]);
      @(posedge clk); @(negedge clk);
    end
    // Now in T2 of an external cycle: long wait run (R6)
    ext_access = 1'b0; ready = 1'b0;
    chk("R6 long wait T2", B2);
    @(posedge clk); @(negedge clk);
    chk("R6 long wait T3", B3);
    @(posedge clk); @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      chk("R6 R7 held in TW", BW);
      @(posedge clk); @(negedge clk);
    end
    ready = 1'b1;
    chk("R6 last TW", BW);
    @(posedge clk); @(negedge clk);
    chk("R8 T4 after long wait", B4);
    @(posedge clk); @(negedge clk);
    chk("R8 back to T1", B1);
    // Reset during a wait beat (R1)
    ext_access = 1'b1; ready = 1'b0;
    @(posedge clk); @(negedge clk);
    ext_access = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6 T3 before reset", B3);
    @(posedge clk); @(negedge clk);
    chk("R6 TW before reset", BW);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 reset from TW", B1);
    rst = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

endmodule